// File: doc/BRIEF.md
# Two-Stage Virtually-Indexed, Physically-Tagged Instruction Cache

This block is the instruction cache of a processor front end. A fetch address from the next-PC logic enters the tag-lookup stage. There its set index selects an entry in separate tag, valid/replacement-state and line-data memories. On the following cycle the tag-verify stage compares the stored physical tags with the physical address, which the translation unit delivers one cycle after the fetch. A hit returns the 32-bit instruction word on the next clock edge.

A miss raises a line-fill request carrying the physical line address. The cache then stalls the front end until the fill data arrives. The fill data is written into the arrays, and the requested word is returned directly from the fill bus.

A flush/redirect input drops the fetch in either stage. A fill that is already under way still completes into the arrays, but it produces no response. The cache can be built direct-mapped or 2-way set associative. In the 2-way build, one bit per set tracks the least recently used way, and that way is the fill victim.

Top module: `icache_vipt`

## Requirements
- R1: After reset every line is invalid, `resp_valid` and `fill_req` are low and `fetch_ready` is high.
- R2: A fetch accepted in cycle t, with its physical address on `tlb_paddr` in cycle t+1, yields `resp_valid` high in cycle t+2 when the line is present. `resp_instr` is the word of the line at word offset `fetch_vaddr[3:2]`.
- R3: A miss detected in cycle t+1 raises `fill_req` in cycle t+2, with `fill_addr` equal to the physical address with bits [3:0] cleared. Both hold unchanged until a cycle with `fill_ack` high.
- R4: `fetch_ready` is low in the verify cycle of a miss and stays low while the fill is outstanding.
- R5: In the cycle after `fill_valid` (accepted only after the acknowledge), `resp_valid` is high and `resp_instr` is word k of `fill_data`, taken from bits [32k+31:32k]. `fetch_ready` is high again and the line hits afterwards.
- R6: The tag check uses physical bits [31:8]. A fetch whose virtual address matches a cached line but whose physical tag differs misses.
- R7: In the 2-way build, two lines with different physical tags in the same set are both held and both hit.
- R8: The fill victim is the least recently used way of the set, where both hits and fills count as uses.
- R9: Asserting `kill` in the verify cycle of a fetch suppresses its response. If that fetch missed, no fill is requested.
- R10: Asserting `kill` while a fill is outstanding suppresses that fill's response. The line is still installed and hits on a later fetch.
- R11: A fetch presented in the same cycle as `kill` is not accepted and produces neither a response nor a fill request.
- R12: Fetches presented on consecutive cycles that all hit produce responses on consecutive cycles, in order.
- R13: The set is chosen by virtual bits [7:4] only. A second virtual address with different upper bits that maps to the same physical line hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_vaddr | input | 32 | Virtual fetch address (byte address) |
| fetch_ready | output | 1 | Cache can accept a fetch this cycle |
| tlb_paddr | input | 32 | Physical address of the fetch now in the verify stage |
| kill | input | 1 | Flush/redirect: drops fetches in both stages |
| resp_valid | output | 1 | Instruction word is valid |
| resp_instr | output | 32 | Fetched instruction word |
| fill_req | output | 1 | Line-fill request |
| fill_addr | output | 32 | Physical line address of the fill, low offset bits zero |
| fill_ack | input | 1 | Fill request accepted |
| fill_valid | input | 1 | Fill line data present |
| fill_data | input | 128 | Fill line data, word k in bits [32k+31:32k] |

## Verification
A hit is due two edges after the fetch is driven: one edge loads the verify stage and one loads the response register. A miss shows `fill_req` at the same point. The fill response appears one edge after `fill_valid`, and a kill shows its effect on the edge that ends the killed cycle.

The bench drives every input on the falling edge. It reads the outputs on a later falling edge, at exactly these offsets, so each check falls on the cycle its requirement names. Stall, hold and pipelined-hit sequences are stepped one falling edge at a time, with a check in every cycle.

// File: rtl/icache_pkg.sv
package icache_pkg;

    localparam int INSTR_W    = 32;
    localparam int BYTE_OFF_W = 2;

    typedef enum logic [1:0] {
        FILL_IDLE,
        FILL_REQ,
        FILL_WAIT
    } fill_state_e;

    typedef struct packed {
        logic               valid;
        logic [INSTR_W-1:0] instr;
    } fetch_resp_t;

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/icache_tag_way.sv
module icache_tag_way #(
    parameter int SETS  = 16,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_vld,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [SETS-1:0]  vld_bits;
    logic [TAG_W-1:0] tag_mem [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_bits <= '0;
        end else if (wr_en) begin
            vld_bits[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    assign rd_tag = tag_mem[rd_idx];
    assign rd_vld = vld_bits[rd_idx];

endmodule

// File: rtl/icache_data_way.sv
module icache_data_way #(
    parameter int SETS   = 16,
    parameter int LINE_W = 128,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line
);

    logic [LINE_W-1:0] line_mem [SETS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_mem[wr_idx] <= wr_line;
        end
    end

    assign rd_line = line_mem[rd_idx];

endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
    parameter int SETS  = 16,
    parameter int WAYS  = 2,
    parameter int WAY_W = 1,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WAY_W-1:0] victim,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [WAY_W-1:0] upd_way
);

    generate
        if (WAYS == 2) begin : g_two_way
            // bit set = way 1 is the next victim
            logic [SETS-1:0] evict_bits;

            always_ff @(posedge clk) begin
                if (rst) begin
                    evict_bits <= '0;
                end else if (upd_en) begin
                    evict_bits[upd_idx] <= ~upd_way[0];
                end
            end

            assign victim = WAY_W'(evict_bits[rd_idx]);
        end else begin : g_one_way
            logic unused_lru;
            assign unused_lru = ^{clk, rst, rd_idx, upd_en, upd_idx, upd_way};
            assign victim     = '0;
        end
    endgenerate

endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
    import icache_pkg::*;
#(
    parameter int LADDR_W = 28,
    parameter int WOFF_W  = 2,
    parameter int WAY_W   = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [LADDR_W-1:0] start_line,
    input  logic [WOFF_W-1:0]  start_word,
    input  logic [WAY_W-1:0]   start_way,
    input  logic               kill,
    input  logic               fill_ack,
    input  logic               fill_valid,
    output logic               fill_req,
    output logic               busy,
    output logic               in_wait,
    output logic               done,
    output logic               deliver,
    output logic [LADDR_W-1:0] line,
    output logic [WOFF_W-1:0]  word,
    output logic [WAY_W-1:0]   way
);

    fill_state_e state;
    logic        dropped;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FILL_IDLE;
            dropped <= 1'b0;
            line    <= '0;
            word    <= '0;
            way     <= '0;
        end else begin
            case (state)
                FILL_IDLE: begin
                    if (start) begin
                        state   <= FILL_REQ;
                        dropped <= 1'b0;
                        line    <= start_line;
                        word    <= start_word;
                        way     <= start_way;
                    end
                end
                FILL_REQ: begin
                    if (kill) dropped <= 1'b1;
                    if (fill_ack) state <= FILL_WAIT;
                end
                FILL_WAIT: begin
                    if (kill) dropped <= 1'b1;
                    if (fill_valid) state <= FILL_IDLE;
                end
                default: state <= FILL_IDLE;
            endcase
        end
    end

    assign fill_req = (state == FILL_REQ);
    assign in_wait  = (state == FILL_WAIT);
    assign busy     = (state != FILL_IDLE);
    assign done     = in_wait && fill_valid;
    assign deliver  = done && !dropped && !kill;

endmodule

// File: rtl/icache_vipt.sv
module icache_vipt
    import icache_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_BITS  = 12,
    parameter int SETS       = 16,
    parameter int LINE_WORDS = 4,
    parameter int WAYS       = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          fetch_valid,
    input  logic [VA_W-1:0]               fetch_vaddr,
    output logic                          fetch_ready,
    input  logic [PA_W-1:0]               tlb_paddr,
    input  logic                          kill,
    output logic                          resp_valid,
    output logic [INSTR_W-1:0]            resp_instr,
    output logic                          fill_req,
    output logic [PA_W-1:0]               fill_addr,
    input  logic                          fill_ack,
    input  logic                          fill_valid,
    input  logic [LINE_WORDS*INSTR_W-1:0] fill_data
);

    localparam int WOFF_W  = $clog2(LINE_WORDS);
    localparam int OFF_W   = BYTE_OFF_W + WOFF_W;
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = PA_W - OFF_W - IDX_W;
    localparam int LADDR_W = PA_W - OFF_W;
    localparam int LINE_W  = LINE_WORDS * INSTR_W;
    localparam int WAY_W   = at_least_one($clog2(WAYS));

    generate
        if (OFF_W + IDX_W > PAGE_BITS) begin : g_bad_index
            $error("index and offset bits must fit inside the page offset");
        end
        if (WAYS != 1 && WAYS != 2) begin : g_bad_ways
            $error("WAYS must be 1 or 2");
        end
        if (LINE_WORDS < 2) begin : g_bad_line
            $error("LINE_WORDS must be at least 2");
        end
    endgenerate

    // ---------------- lookup stage ----------------
    logic             fire;
    logic [IDX_W-1:0] lk_idx;
    logic [WOFF_W-1:0] lk_word;

    logic [TAG_W-1:0]  rd_tag  [WAYS];
    logic [WAYS-1:0]   rd_vld;
    logic [LINE_W-1:0] rd_line [WAYS];

    // fill side
    logic               fc_req;
    logic               fc_busy;
    logic               fill_wait;
    logic               fc_done;
    logic               fc_deliver;
    logic [LADDR_W-1:0] fc_line;
    logic [WOFF_W-1:0]  fc_word;
    logic [WAY_W-1:0]   fc_way;
    logic [IDX_W-1:0]   fc_idx;
    logic [TAG_W-1:0]   fc_tag;

    assign lk_idx  = fetch_vaddr[OFF_W +: IDX_W];
    assign lk_word = fetch_vaddr[BYTE_OFF_W +: WOFF_W];
    assign fc_idx  = fc_line[IDX_W-1:0];
    assign fc_tag  = fc_line[LADDR_W-1:IDX_W];

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic way_wr;
            assign way_wr = fc_done && (fc_way == WAY_W'(w));

            icache_tag_way #(.SETS(SETS), .TAG_W(TAG_W)) tag_i (
                .clk    (clk),
                .rst    (rst),
                .rd_idx (lk_idx),
                .rd_tag (rd_tag[w]),
                .rd_vld (rd_vld[w]),
                .wr_en  (way_wr),
                .wr_idx (fc_idx),
                .wr_tag (fc_tag)
            );

            icache_data_way #(.SETS(SETS), .LINE_W(LINE_W)) data_i (
                .clk     (clk),
                .rd_idx  (lk_idx),
                .rd_line (rd_line[w]),
                .wr_en   (way_wr),
                .wr_idx  (fc_idx),
                .wr_line (fill_data)
            );
        end
    endgenerate

    // ---------------- verify stage registers ----------------
    logic              tv_valid;
    logic [IDX_W-1:0]  tv_idx;
    logic [WOFF_W-1:0] tv_word;
    logic [TAG_W-1:0]  tv_tag  [WAYS];
    logic [WAYS-1:0]   tv_vld;
    logic [LINE_W-1:0] tv_line [WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            tv_valid <= 1'b0;
        end else begin
            tv_valid <= fire;
        end
    end

    always_ff @(posedge clk) begin
        if (fire) begin
            tv_idx  <= lk_idx;
            tv_word <= lk_word;
            tv_vld  <= rd_vld;
            for (int w = 0; w < WAYS; w++) begin
                tv_tag[w]  <= rd_tag[w];
                tv_line[w] <= rd_line[w];
            end
        end
    end

    // ---------------- tag compare ----------------
    logic [TAG_W-1:0]   p_tag;
    logic [LADDR_W-1:0] p_line;
    logic               hit_any;
    logic [WAY_W-1:0]   hit_way;
    logic [LINE_W-1:0]  hit_line;
    logic [INSTR_W-1:0] hit_word;
    logic               hit_deliver;
    logic               miss_start;
    logic [WAY_W-1:0]   victim;

    assign p_tag  = tlb_paddr[PA_W-1 -: TAG_W];
    assign p_line = tlb_paddr[PA_W-1:OFF_W];

    always_comb begin
        hit_any  = 1'b0;
        hit_way  = '0;
        hit_line = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (tv_vld[w] && (tv_tag[w] == p_tag)) begin
                hit_any  = 1'b1;
                hit_way  = WAY_W'(w);
                hit_line = tv_line[w];
            end
        end
    end

    assign hit_word    = hit_line[tv_word*INSTR_W +: INSTR_W];
    assign hit_deliver = tv_valid && hit_any && !kill;
    assign miss_start  = tv_valid && !hit_any && !kill;

    assign fetch_ready = !fc_busy && !(tv_valid && !hit_any);
    assign fire        = fetch_valid && fetch_ready && !kill;

    // ---------------- replacement state ----------------
    logic             lru_upd;
    logic [IDX_W-1:0] lru_idx;
    logic [WAY_W-1:0] lru_way;

    assign lru_upd = hit_deliver || fc_done;
    assign lru_idx = fc_done ? fc_idx : tv_idx;
    assign lru_way = fc_done ? fc_way : hit_way;

    icache_lru #(.SETS(SETS), .WAYS(WAYS), .WAY_W(WAY_W)) lru_i (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (tv_idx),
        .victim  (victim),
        .upd_en  (lru_upd),
        .upd_idx (lru_idx),
        .upd_way (lru_way)
    );

    // ---------------- fill handling ----------------
    icache_fill_ctrl #(.LADDR_W(LADDR_W), .WOFF_W(WOFF_W), .WAY_W(WAY_W)) fill_i (
        .clk        (clk),
        .rst        (rst),
        .start      (miss_start),
        .start_line (p_line),
        .start_word (tv_word),
        .start_way  (victim),
        .kill       (kill),
        .fill_ack   (fill_ack),
        .fill_valid (fill_valid),
        .fill_req   (fc_req),
        .busy       (fc_busy),
        .in_wait    (fill_wait),
        .done       (fc_done),
        .deliver    (fc_deliver),
        .line       (fc_line),
        .word       (fc_word),
        .way        (fc_way)
    );

    assign fill_req  = fc_req;
    assign fill_addr = {fc_line, {OFF_W{1'b0}}};

    // ---------------- response register ----------------
    fetch_resp_t resp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else if (hit_deliver) begin
            resp_q <= '{valid: 1'b1, instr: hit_word};
        end else if (fc_deliver) begin
            resp_q <= '{valid: 1'b1, instr: fill_data[fc_word*INSTR_W +: INSTR_W]};
        end else begin
            resp_q.valid <= 1'b0;
        end
    end

    assign resp_valid = resp_q.valid;
    assign resp_instr = resp_q.instr;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{fetch_vaddr, tlb_paddr};

endmodule

// File: rtl/icache_vipt_chk.sv
module icache_vipt_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            kill,
    input logic            fetch_ready,
    input logic            fill_req,
    input logic            fill_ack,
    input logic [PA_W-1:0] fill_addr,
    input logic            fill_valid,
    input logic            resp_valid,
    input logic            tv_valid,
    input logic            tv_hit,
    input logic            fill_wait
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!fill_req && !resp_valid && fetch_ready));

    assert_hit_resp_R2: assert property (@(posedge clk) disable iff (rst)
        (tv_valid && tv_hit && !kill) |=> resp_valid);

    assert_miss_req_R3: assert property (@(posedge clk) disable iff (rst)
        (tv_valid && !tv_hit && !kill) |=> fill_req);

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !fill_ack) |=> (fill_req && $stable(fill_addr)));

    assert_stall_R4: assert property (@(posedge clk) disable iff (rst)
        (fill_req || fill_wait) |-> !fetch_ready);

    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        (fill_wait && fill_valid) |=> (fetch_ready && !fill_req));

    assert_kill_silent_R9: assert property (@(posedge clk) disable iff (rst)
        kill |=> !resp_valid);

    assert_kill_no_fill_R9: assert property (@(posedge clk) disable iff (rst)
        (tv_valid && !tv_hit && kill && !fill_req && !fill_wait) |=> !fill_req);

endmodule

bind icache_vipt icache_vipt_chk #(.PA_W(PA_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .kill        (kill),
    .fetch_ready (fetch_ready),
    .fill_req    (fill_req),
    .fill_ack    (fill_ack),
    .fill_addr   (fill_addr),
    .fill_valid  (fill_valid),
    .resp_valid  (resp_valid),
    .tv_valid    (tv_valid),
    .tv_hit      (hit_any),
    .fill_wait   (fill_wait)
);

// File: tb/icache_vipt_tb.sv
module icache_vipt_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fetch_valid = 1'b0;
    logic [31:0]  fetch_vaddr = '0;
    logic         fetch_ready;
    logic [31:0]  tlb_paddr = '0;
    logic         kill = 1'b0;
    logic         resp_valid;
    logic [31:0]  resp_instr;
    logic         fill_req;
    logic [31:0]  fill_addr;
    logic         fill_ack = 1'b0;
    logic         fill_valid = 1'b0;
    logic [127:0] fill_data = '0;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    icache_vipt dut_i (
        .clk         (clk),
        .rst         (rst),
        .fetch_valid (fetch_valid),
        .fetch_vaddr (fetch_vaddr),
        .fetch_ready (fetch_ready),
        .tlb_paddr   (tlb_paddr),
        .kill        (kill),
        .resp_valid  (resp_valid),
        .resp_instr  (resp_instr),
        .fill_req    (fill_req),
        .fill_addr   (fill_addr),
        .fill_ack    (fill_ack),
        .fill_valid  (fill_valid),
        .fill_data   (fill_data)
    );

    // ---- helpers ----
    function automatic logic [31:0] va(input logic [23:0] hi, input logic [3:0] idx, input logic [1:0] w);
        return {hi, idx, w, 2'b00};
    endfunction

    function automatic logic [31:0] word_of(input logic [31:0] pa, input int k);
        return {pa[31:4], 4'(k)} ^ 32'hA5C3_0000;
    endfunction

    function automatic logic [127:0] line_of(input logic [31:0] pa);
        logic [127:0] l;
        for (int k = 0; k < 4; k++) l[k*32 +: 32] = word_of(pa, k);
        return l;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // returns the fill: ack after ack_delay held cycles, then data
    task automatic serve_fill(input logic [31:0] pa, input int ack_delay, input string rq);
        for (int i = 0; i < ack_delay; i++) begin
            chk(fill_req == 1'b1, "R3", "fill_req held", 128'(fill_req), 1);
            chk(fill_addr == {pa[31:4], 4'b0}, "R3", "fill_addr held", 128'(fill_addr), 128'({pa[31:4], 4'b0}));
            chk(fetch_ready == 1'b0, "R4", "stalled while req", 128'(fetch_ready), 0);
            @(negedge clk);
        end
        fill_ack = 1'b1;
        @(negedge clk);
        fill_ack = 1'b0;
        chk(fill_req == 1'b0, "R3", "req drops after ack", 128'(fill_req), 0);
        chk(fetch_ready == 1'b0, "R4", "stalled while waiting", 128'(fetch_ready), 0);
        fill_valid = 1'b1;
        fill_data  = line_of(pa);
        @(negedge clk);
        fill_valid = 1'b0;
        chk(resp_valid == 1'b1, rq, "fill resp_valid", 128'(resp_valid), 1);
        chk(resp_instr == word_of(pa, int'(pa[3:2])), rq, "fill resp_instr",
            128'(resp_instr), 128'(word_of(pa, int'(pa[3:2]))));
        chk(fetch_ready == 1'b1, "R5", "ready after fill", 128'(fetch_ready), 1);
    endtask

    task automatic access(input logic [31:0] vad, input logic [31:0] pa,
                          input bit exp_hit, input int ack_delay, input string rq);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_vaddr = vad;
        @(negedge clk);
        fetch_valid = 1'b0;
        tlb_paddr   = pa;
        #0.1;
        chk(fetch_ready == exp_hit, "R4", "ready in verify cycle", 128'(fetch_ready), 128'(exp_hit));
        @(negedge clk);
        if (exp_hit) begin
            chk(resp_valid == 1'b1, rq, "hit resp_valid", 128'(resp_valid), 1);
            chk(resp_instr == word_of(pa, int'(pa[3:2])), rq, "hit resp_instr",
                128'(resp_instr), 128'(word_of(pa, int'(pa[3:2]))));
            chk(fill_req == 1'b0, rq, "no fill on hit", 128'(fill_req), 0);
        end else begin
            chk(resp_valid == 1'b0, rq, "no resp on miss", 128'(resp_valid), 0);
            chk(fill_req == 1'b1, "R3", "fill_req raised", 128'(fill_req), 1);
            chk(fill_addr == {pa[31:4], 4'b0}, "R3", "fill_addr", 128'(fill_addr), 128'({pa[31:4], 4'b0}));
            serve_fill(pa, ack_delay, rq);
        end
    endtask

    // ---- scenarios ----
    localparam logic [23:0] TA = 24'h10_0013, TB = 24'h22_0023, TC = 24'h37_0033;

    task automatic t_reset();
        chk(resp_valid == 1'b0, "R1", "reset resp_valid", 128'(resp_valid), 0);
        chk(fill_req == 1'b0, "R1", "reset fill_req", 128'(fill_req), 0);
        chk(fetch_ready == 1'b1, "R1", "reset fetch_ready", 128'(fetch_ready), 1);
    endtask

    task automatic t_cold_and_ways();
        // R1: first fetch after reset misses; R3/R4 hold for 3 cycles
        access(va(24'h0AB, 4'd3, 2'd1), {TA, 4'd3, 2'd1, 2'b00}, 1'b0, 3, "R5");
        access(va(24'h0AB, 4'd3, 2'd2), {TA, 4'd3, 2'd2, 2'b00}, 1'b1, 0, "R2");
        // R6: same virtual address, other physical tag
        access(va(24'h0AB, 4'd3, 2'd1), {TB, 4'd3, 2'd1, 2'b00}, 1'b0, 0, "R6");
        // R7 and R13: both held; alias virtual address for TA
        access(va(24'h777, 4'd3, 2'd3), {TA, 4'd3, 2'd3, 2'b00}, 1'b1, 0, "R13");
        access(va(24'h0AB, 4'd3, 2'd0), {TB, 4'd3, 2'd0, 2'b00}, 1'b1, 0, "R7");
    endtask

    task automatic t_lru();
        access(va(24'h0AB, 4'd3, 2'd0), {TA, 4'd3, 2'd0, 2'b00}, 1'b1, 0, "R8");
        access(va(24'h0AB, 4'd3, 2'd2), {TC, 4'd3, 2'd2, 2'b00}, 1'b0, 0, "R8");
        access(va(24'h0AB, 4'd3, 2'd1), {TA, 4'd3, 2'd1, 2'b00}, 1'b1, 0, "R8");
        access(va(24'h0AB, 4'd3, 2'd1), {TB, 4'd3, 2'd1, 2'b00}, 1'b0, 0, "R8");
    endtask

    task automatic t_back_to_back();
        logic [31:0] p [3];
        for (int k = 0; k < 3; k++) p[k] = {TA, 4'd3, 2'(k), 2'b00};
        @(negedge clk);
        fetch_valid = 1'b1; fetch_vaddr = va(24'h0AB, 4'd3, 2'd0);
        @(negedge clk);
        fetch_vaddr = va(24'h0AB, 4'd3, 2'd1); tlb_paddr = p[0];
        @(negedge clk);
        fetch_vaddr = va(24'h0AB, 4'd3, 2'd2); tlb_paddr = p[1];
        chk(resp_valid && resp_instr == word_of(p[0], 0), "R12", "stream word 0", 128'(resp_instr), 128'(word_of(p[0], 0)));
        @(negedge clk);
        fetch_valid = 1'b0; tlb_paddr = p[2];
        chk(resp_valid && resp_instr == word_of(p[1], 1), "R12", "stream word 1", 128'(resp_instr), 128'(word_of(p[1], 1)));
        @(negedge clk);
        chk(resp_valid && resp_instr == word_of(p[2], 2), "R12", "stream word 2", 128'(resp_instr), 128'(word_of(p[2], 2)));
        @(negedge clk);
        chk(resp_valid == 1'b0, "R12", "stream ends", 128'(resp_valid), 0);
    endtask

    task automatic t_kill_verify();
        logic [31:0] pd;
        pd = {24'h44_0045, 4'd5, 2'd1, 2'b00};
        // killed hit
        @(negedge clk);
        fetch_valid = 1'b1; fetch_vaddr = va(24'h0AB, 4'd3, 2'd0);
        @(negedge clk);
        fetch_valid = 1'b0; tlb_paddr = {TA, 4'd3, 2'd0, 2'b00}; kill = 1'b1;
        @(negedge clk);
        kill = 1'b0;
        chk(resp_valid == 1'b0, "R9", "killed hit silent", 128'(resp_valid), 0);
        // killed miss
        fetch_valid = 1'b1; fetch_vaddr = va(24'h0CD, 4'd5, 2'd1);
        @(negedge clk);
        fetch_valid = 1'b0; tlb_paddr = pd; kill = 1'b1;
        @(negedge clk);
        kill = 1'b0;
        chk(fill_req == 1'b0, "R9", "killed miss no fill", 128'(fill_req), 0);
        chk(resp_valid == 1'b0, "R9", "killed miss silent", 128'(resp_valid), 0);
        chk(fetch_ready == 1'b1, "R9", "ready after kill", 128'(fetch_ready), 1);
        access(va(24'h0CD, 4'd5, 2'd1), pd, 1'b0, 0, "R9");
    endtask

    task automatic t_kill_pending();
        logic [31:0] pe;
        pe = {24'h55_0056, 4'd6, 2'd2, 2'b00};
        @(negedge clk);
        fetch_valid = 1'b1; fetch_vaddr = va(24'h0EF, 4'd6, 2'd2);
        @(negedge clk);
        fetch_valid = 1'b0; tlb_paddr = pe;
        @(negedge clk);
        chk(fill_req == 1'b1, "R10", "fill_req before kill", 128'(fill_req), 1);
        fill_ack = 1'b1;
        @(negedge clk);
        fill_ack = 1'b0; kill = 1'b1;
        @(negedge clk);
        kill = 1'b0; fill_valid = 1'b1; fill_data = line_of(pe);
        @(negedge clk);
        fill_valid = 1'b0;
        chk(resp_valid == 1'b0, "R10", "killed fill silent", 128'(resp_valid), 0);
        chk(fetch_ready == 1'b1, "R10", "ready after killed fill", 128'(fetch_ready), 1);
        access(va(24'h0EF, 4'd6, 2'd3), {24'h55_0056, 4'd6, 2'd3, 2'b00}, 1'b1, 0, "R10");
    endtask

    task automatic t_kill_accept();
        @(negedge clk);
        fetch_valid = 1'b1; fetch_vaddr = va(24'h123, 4'd7, 2'd0); kill = 1'b1;
        @(negedge clk);
        fetch_valid = 1'b0; kill = 1'b0; tlb_paddr = {24'h66_0067, 4'd7, 2'd0, 2'b00};
        @(negedge clk);
        chk(fill_req == 1'b0, "R11", "not accepted: no fill", 128'(fill_req), 0);
        chk(resp_valid == 1'b0, "R11", "not accepted: no resp", 128'(resp_valid), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cold_and_ways();
        t_lru();
        t_back_to_back();
        t_kill_verify();
        t_kill_pending();
        t_kill_accept();
        repeat (3) @(negedge clk);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

endmodule